// File: doc/BRIEF.md
# UART register and interrupt block

This block is the memory-mapped control and status front end of a serial port. A simple single-cycle 32-bit bus reaches four word registers: a control word, a receive-data word, a transmit-data word and a status word. Bus accesses become framing configuration outputs, enable bits, and one-cycle push and pop strobes toward FIFOs and serial engines that sit outside the block.

The status word mixes two kinds of bits. Live flags (FIFO empty and full, modem line states, FIFO fill level, transmitter busy) are mirrored straight from the outside and ignore writes. Sticky bits (receive and transmit pending, overrun, transmit-FIFO error, receive line error) are set by hardware events and cleared by software writing one to them. A single level-high interrupt line combines the pending bits with their enables.

Reads return data combinationally in the cycle of the request. Writes take effect at the clock edge that ends the request cycle. Accesses whose low two address bits are not zero are ignored.

Top module: `uart_regif`

## Requirements
- R1: The control word sits at byte offset 0x0, and it reads back exactly what was written, masked to its defined bits (0x001FD077). Every undefined bit reads 0, and any unmapped or misaligned address reads 0.
- R2: The control fields drive the configuration outputs. Bits 1:0 give the data length code, bit 2 selects two stop bits, bits 6:4 give the parity code, bit 12 enables flow control, bit 15 is the enable, bits 16/17 are the RX/TX DMA enables, and bit 20 is loopback.
- R3: A read of offset 0x4 returns the receive character in bits 7:0 with zeros above it. It pulses rx_pop_o in that cycle only when the RX FIFO is not empty.
- R4: A write to offset 0x8 pulses tx_push_o with wdata bits 7:0 on tx_data_o when the TX FIFO is not full. When the TX FIFO is full, the write is dropped (no push) and status bit 3 (TX FIFO error) sets.
- R5: Status (offset 0xC) live flags: bit 5 RX empty, bit 6 TX full, bit 7 CTS, bit 8 RTS, bit 10 TX empty, bit 17 transmitter busy. These bits follow the inputs and are unaffected by writes. Bit 9 and bits 31:18 read 0.
- R6: Status bits 16:11 report the TX FIFO level when control bit 14 is 1, and the RX FIFO level when it is 0.
- R7: Status bits 4:0 are sticky. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A hardware set in the same cycle as a clear wins.
- R8: Status bit 0 (RX pending) sets on every cycle in which the RX FIFO is not empty.
- R9: Status bit 1 (TX pending) sets on every cycle in which the TX level is below TX_DEPTH/2.
- R10: A pulse on rx_overrun_i sets status bit 2, and a pulse on rx_line_err_i sets status bit 4.
- R11: irq_o = enable AND ((bit 0 AND control bit 18) OR (bit 1 AND control bit 19)).
- R12: After reset the control word and all sticky bits are 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| rx_data_i | input | 8 | Head character of the RX FIFO |
| rx_empty_i | input | 1 | RX FIFO empty |
| rx_level_i | input | 6 | RX FIFO fill level |
| rx_overrun_i | input | 1 | Overrun event pulse |
| rx_line_err_i | input | 1 | Parity/framing/break event pulse |
| rx_pop_o | output | 1 | Pop strobe for the RX FIFO |
| tx_full_i | input | 1 | TX FIFO full |
| tx_empty_i | input | 1 | TX FIFO empty |
| tx_level_i | input | 6 | TX FIFO fill level |
| tx_busy_i | input | 1 | Transmitter shifting |
| tx_push_o | output | 1 | Push strobe for the TX FIFO |
| tx_data_o | output | 8 | Character to push |
| cts_i | input | 1 | CTS line state |
| rts_i | input | 1 | RTS line state |
| data_len_o | output | 2 | Data length code |
| two_stop_o | output | 1 | Two stop bits |
| parity_o | output | 3 | Parity code |
| flow_en_o | output | 1 | Hardware flow control enable |
| en_o | output | 1 | Port enable |
| rx_dma_en_o | output | 1 | RX DMA enable |
| tx_dma_en_o | output | 1 | TX DMA enable |
| loopback_o | output | 1 | Loopback enable |
| irq_o | output | 1 | Level-high interrupt |

## Verification
The bound checker watches the following on every cycle:
- rx_pop_o never fires on an empty RX FIFO, and tx_push_o never fires on a full TX FIFO.
- A write into a full TX FIFO always raises the error bit.
- A non-empty RX FIFO always raises RX pending.
- A write-one clear of the overrun bit takes hold unless a new overrun arrives in the same cycle.
- The interrupt stays low while the port is disabled.

Only the bench scenarios can show the rest:
- The exact read values, the level-source select and the live flags' immunity to writes.
- That set-over-clear priority holds on a held condition.
- The full interrupt equation across enable combinations.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  // word indices (byte offset / 4)
  localparam int unsigned WI_CTRL = 0;
  localparam int unsigned WI_RXD  = 1;
  localparam int unsigned WI_TXD  = 2;
  localparam int unsigned WI_STAT = 3;

  localparam logic [31:0] CTRL_WMASK = 32'h001F_D077;
  localparam int unsigned LVL_W = 6;

  // sticky status bit indices
  localparam int unsigned NSTICKY  = 5;
  localparam int unsigned SB_RXP   = 0;
  localparam int unsigned SB_TXP   = 1;
  localparam int unsigned SB_OVR   = 2;
  localparam int unsigned SB_TXERR = 3;
  localparam int unsigned SB_LERR  = 4;

  typedef struct packed {
    logic       loopback;
    logic       tx_ie;
    logic       rx_ie;
    logic       tx_dma;
    logic       rx_dma;
    logic       en;
    logic       lvl_tx;
    logic       flow;
    logic [2:0] parity;
    logic       two_stop;
    logic [1:0] len;
  } ctrl_t;

  typedef struct packed {
    logic             rx_empty;
    logic             tx_full;
    logic             cts;
    logic             rts;
    logic             tx_empty;
    logic             tx_busy;
    logic [LVL_W-1:0] rx_level;
    logic [LVL_W-1:0] tx_level;
  } live_t;
endpackage

// File: rtl/uart_regif_ctrl.sv
module uart_regif_ctrl
  import uart_regif_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] word_o,
  output ctrl_t       ctrl_o
);
  logic [31:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= wdata_i & CTRL_WMASK;
  end

  assign word_o = q;

  always_comb begin
    ctrl_o.len      = q[1:0];
    ctrl_o.two_stop = q[2];
    ctrl_o.parity   = q[6:4];
    ctrl_o.flow     = q[12];
    ctrl_o.lvl_tx   = q[14];
    ctrl_o.en       = q[15];
    ctrl_o.rx_dma   = q[16];
    ctrl_o.tx_dma   = q[17];
    ctrl_o.rx_ie    = q[18];
    ctrl_o.tx_ie    = q[19];
    ctrl_o.loopback = q[20];
  end
endmodule

// File: rtl/uart_regif_sticky.sv
module uart_regif_sticky #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic b;
    // hardware set beats a same-cycle write-one clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       b <= 1'b0;
      else if (set_i[i]) b <= 1'b1;
      else if (clr_i[i]) b <= 1'b0;
    end
    assign q_o[i] = b;
  end
endmodule

// File: rtl/uart_regif_rdmux.sv
module uart_regif_rdmux
  import uart_regif_pkg::*;
(
  input  logic               sel_ctrl_i,
  input  logic               sel_rxd_i,
  input  logic               sel_stat_i,
  input  logic [31:0]        ctrl_word_i,
  input  logic               lvl_tx_i,
  input  logic [7:0]         rx_data_i,
  input  logic [NSTICKY-1:0] sticky_i,
  input  live_t              live_i,
  output logic [31:0]        rdata_o
);
  logic [31:0]      stat;
  logic [LVL_W-1:0] lvl;

  assign lvl = lvl_tx_i ? live_i.tx_level : live_i.rx_level;

  always_comb begin
    stat         = '0;
    stat[4:0]    = sticky_i;
    stat[5]      = live_i.rx_empty;
    stat[6]      = live_i.tx_full;
    stat[7]      = live_i.cts;
    stat[8]      = live_i.rts;
    stat[10]     = live_i.tx_empty;
    stat[16:11]  = lvl;
    stat[17]     = live_i.tx_busy;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl_i)      rdata_o = ctrl_word_i;
    else if (sel_rxd_i)  rdata_o = {24'h0, rx_data_i};
    else if (sel_stat_i) rdata_o = stat;
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned TX_DEPTH = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_empty_i,
  input  logic [5:0]        rx_level_i,
  input  logic              rx_overrun_i,
  input  logic              rx_line_err_i,
  output logic              rx_pop_o,
  input  logic              tx_full_i,
  input  logic              tx_empty_i,
  input  logic [5:0]        tx_level_i,
  input  logic              tx_busy_i,
  output logic              tx_push_o,
  output logic [7:0]        tx_data_o,
  input  logic              cts_i,
  input  logic              rts_i,
  output logic [1:0]        data_len_o,
  output logic              two_stop_o,
  output logic [2:0]        parity_o,
  output logic              flow_en_o,
  output logic              en_o,
  output logic              rx_dma_en_o,
  output logic              tx_dma_en_o,
  output logic              loopback_o,
  output logic              irq_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam logic [LVL_W-1:0] TX_HALF = LVL_W'(TX_DEPTH / 2);

  logic [WIDX_W-1:0] widx;
  logic              acc;
  logic              hit_ctrl, hit_rxd, hit_txd, hit_stat;
  logic [31:0]       ctrl_word;
  ctrl_t             ctrl;
  logic [NSTICKY-1:0] sticky_q, sticky_set, sticky_clr;
  live_t             live;

  assign widx     = addr_i[ADDR_W-1:2];
  assign acc      = req_i && (addr_i[1:0] == 2'b00);
  assign hit_ctrl = acc && (widx == WIDX_W'(WI_CTRL));
  assign hit_rxd  = acc && (widx == WIDX_W'(WI_RXD));
  assign hit_txd  = acc && (widx == WIDX_W'(WI_TXD));
  assign hit_stat = acc && (widx == WIDX_W'(WI_STAT));

  uart_regif_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (hit_ctrl && we_i),
    .wdata_i (wdata_i),
    .word_o  (ctrl_word),
    .ctrl_o  (ctrl)
  );

  // FIFO strobes
  assign rx_pop_o  = hit_rxd && !we_i && !rx_empty_i;
  assign tx_push_o = hit_txd && we_i && !tx_full_i;
  assign tx_data_o = wdata_i[7:0];

  always_comb begin
    sticky_set           = '0;
    sticky_set[SB_RXP]   = !rx_empty_i;
    sticky_set[SB_TXP]   = tx_level_i < TX_HALF;
    sticky_set[SB_OVR]   = rx_overrun_i;
    sticky_set[SB_TXERR] = hit_txd && we_i && tx_full_i;
    sticky_set[SB_LERR]  = rx_line_err_i;
  end

  assign sticky_clr = (hit_stat && we_i) ? wdata_i[NSTICKY-1:0] : '0;

  uart_regif_sticky #(.N(NSTICKY)) u_sticky (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sticky_set),
    .clr_i  (sticky_clr),
    .q_o    (sticky_q)
  );

  always_comb begin
    live.rx_empty = rx_empty_i;
    live.tx_full  = tx_full_i;
    live.cts      = cts_i;
    live.rts      = rts_i;
    live.tx_empty = tx_empty_i;
    live.tx_busy  = tx_busy_i;
    live.rx_level = rx_level_i;
    live.tx_level = tx_level_i;
  end

  uart_regif_rdmux u_rdmux (
    .sel_ctrl_i  (hit_ctrl && !we_i),
    .sel_rxd_i   (hit_rxd && !we_i),
    .sel_stat_i  (hit_stat && !we_i),
    .ctrl_word_i (ctrl_word),
    .lvl_tx_i    (ctrl.lvl_tx),
    .rx_data_i   (rx_data_i),
    .sticky_i    (sticky_q),
    .live_i      (live),
    .rdata_o     (rdata_o)
  );

  assign data_len_o  = ctrl.len;
  assign two_stop_o  = ctrl.two_stop;
  assign parity_o    = ctrl.parity;
  assign flow_en_o   = ctrl.flow;
  assign en_o        = ctrl.en;
  assign rx_dma_en_o = ctrl.rx_dma;
  assign tx_dma_en_o = ctrl.tx_dma;
  assign loopback_o  = ctrl.loopback;

  assign irq_o = ctrl.en && ((sticky_q[SB_RXP] && ctrl.rx_ie) ||
                             (sticky_q[SB_TXP] && ctrl.tx_ie));
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              rx_empty_i,
  input logic              rx_overrun_i,
  input logic              tx_full_i,
  input logic              rx_pop_o,
  input logic              tx_push_o,
  input logic              en_o,
  input logic              irq_o,
  input logic [4:0]        sticky_q
);
  logic wr_txd, wr_stat;
  assign wr_txd  = req_i && we_i && (addr_i == ADDR_W'(8));
  assign wr_stat = req_i && we_i && (addr_i == ADDR_W'(12));

  assert_pop_nonempty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> !rx_empty_i);

  assert_push_notfull_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_o |-> !tx_full_i);

  assert_txerr_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_txd && tx_full_i) |=> sticky_q[3]);

  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[2] && !rx_overrun_i) |=> !sticky_q[2]);

  assert_rxpend_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_empty_i |=> sticky_q[0]);

  assert_irq_gated_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_o |-> !irq_o);
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rx_empty_i   (rx_empty_i),
  .rx_overrun_i (rx_overrun_i),
  .tx_full_i    (tx_full_i),
  .rx_pop_o     (rx_pop_o),
  .tx_push_o    (tx_push_o),
  .en_o         (en_o),
  .irq_o        (irq_o),
  .sticky_q     (sticky_q)
);

// File: tb/sim_uart_regif.sv
`timescale 1ns/1ps
module sim_uart_regif;
  localparam logic [11:0] A_CTRL = 12'h000, A_RXD = 12'h004,
                          A_TXD = 12'h008, A_STAT = 12'h00C;
  localparam logic [31:0] WMASK = 32'h001F_D077;
  localparam logic [31:0] LIVE_MASK = 32'h0003_FDE0;

  logic clk = 0, rst_ni = 0;
  logic req = 0, we = 0;
  logic [11:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [7:0]  rx_data = 0, tx_data;
  logic rx_empty = 1, rx_ovr = 0, rx_lerr = 0, rx_pop;
  logic tx_full = 0, tx_empty = 1, tx_busy = 0, tx_push;
  logic [5:0] rx_level = 0, tx_level = 6'd8;
  logic cts = 0, rts = 0;
  logic [1:0] dlen; logic two_stop; logic [2:0] par;
  logic flow, en, rxdma, txdma, lb, irq;

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] ctrl_m = 0;

  always #4 clk = ~clk;

  uart_regif u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data), .rx_empty_i(rx_empty),
    .rx_level_i(rx_level), .rx_overrun_i(rx_ovr), .rx_line_err_i(rx_lerr),
    .rx_pop_o(rx_pop), .tx_full_i(tx_full), .tx_empty_i(tx_empty),
    .tx_level_i(tx_level), .tx_busy_i(tx_busy), .tx_push_o(tx_push),
    .tx_data_o(tx_data), .cts_i(cts), .rts_i(rts), .data_len_o(dlen),
    .two_stop_o(two_stop), .parity_o(par), .flow_en_o(flow), .en_o(en),
    .rx_dma_en_o(rxdma), .tx_dma_en_o(txdma), .loopback_o(lb), .irq_o(irq));

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
    if (a == A_CTRL) ctrl_m = d & WMASK;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d, output logic p);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1 d = rdata; p = rx_pop;
    @(negedge clk); req = 0;
  endtask

  task automatic wr_tx(logic [7:0] c, output logic p, output logic [7:0] dout);
    @(negedge clk); req = 1; we = 1; addr = A_TXD; wdata = {24'hABCDEF, c};
    #1 p = tx_push; dout = tx_data;
    @(negedge clk); req = 0; we = 0;
  endtask

  function automatic logic [31:0] exp_live(logic [31:0] c);
    logic [31:0] s = '0;
    s[5] = rx_empty; s[6] = tx_full; s[7] = cts; s[8] = rts;
    s[10] = tx_empty; s[17] = tx_busy;
    s[16:11] = c[14] ? tx_level : rx_level;
    return s;
  endfunction

  // idle conditions: no pending sources, then clear all sticky bits
  task automatic quiet();
    @(negedge clk);
    rx_empty = 1; tx_level = 6'd8; rx_ovr = 0; rx_lerr = 0; tx_full = 0;
    wr(A_STAT, 32'h1F);
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d; logic p; logic [7:0] td;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    repeat (2) @(negedge clk);

    // R12 reset state
    rd(A_CTRL, d, p); chk("R12 ctrl reset", d, 0);
    rd(A_STAT, d, p); chk("R12 stat reset", d, 32'h0000_0420);
    chk("R12 irq reset", {31'd0, irq}, 0);

    // R1 readback and masking
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, d, p); chk("R1 ctrl mask", d, WMASK);
    rd(12'h010, d, p); chk("R1 unmapped", d, 0);
    rd(12'h001, d, p); chk("R1 misaligned", d, 0);

    // R2 field outputs
    wr(A_CTRL, 32'h0005_1056);
    chk("R2 fields", {21'd0, lb, txdma, rxdma, en, flow, par, two_stop, dlen},
        {21'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 3'b101, 1'b1, 2'b10});
    wr(A_CTRL, 32'h0012_8001);
    chk("R2 fields b", {21'd0, lb, txdma, rxdma, en, flow, par, two_stop, dlen},
        {21'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 1'b0, 2'b01});
    wr(A_CTRL, 0);

    // R3 receive data
    rx_empty = 0; rx_data = 8'h3C;
    rd(A_RXD, d, p);
    chk("R3 rx data", d, 32'h3C); chk("R3 pop", {31'd0, p}, 1);
    rx_empty = 1; rx_data = 8'hC3;
    rd(A_RXD, d, p); chk("R3 no pop empty", {31'd0, p}, 0);
    quiet();

    // R4 transmit data
    tx_full = 1;
    wr_tx(8'h11, p, td); chk("R4 drop when full", {31'd0, p}, 0);
    tx_full = 0;
    rd(A_STAT, d, p); chk("R4 txerr set", {31'd0, d[3]}, 1);
    wr_tx(8'hA5, p, td); chk("R4 push", {31'd0, p}, 1); chk("R4 push data", {24'd0, td}, 8'hA5);
    quiet();
    rd(A_STAT, d, p); chk("R7 all cleared", d & 32'h1F, 0);

    // R8 rx pending
    @(negedge clk); rx_empty = 0; @(negedge clk); rx_empty = 1;
    rd(A_STAT, d, p); chk("R8 rxp set", {31'd0, d[0]}, 1);
    wr(A_STAT, 32'h0); rd(A_STAT, d, p); chk("R7 write0 keeps", {31'd0, d[0]}, 1);
    wr(A_STAT, 32'h1); rd(A_STAT, d, p); chk("R7 w1c rxp", {31'd0, d[0]}, 0);
    // R7 set wins
    @(negedge clk); rx_empty = 0;
    wr(A_STAT, 32'h1); rd(A_STAT, d, p); chk("R7 set wins", {31'd0, d[0]}, 1);
    quiet();

    // R9 tx pending
    @(negedge clk); tx_level = 6'd7; @(negedge clk); tx_level = 6'd8;
    rd(A_STAT, d, p); chk("R9 txp set below half", {31'd0, d[1]}, 1);
    wr(A_STAT, 32'h2); rd(A_STAT, d, p); chk("R9 txp stays clear at half", {31'd0, d[1]}, 0);

    // R10 error events
    @(negedge clk); rx_ovr = 1; @(negedge clk); rx_ovr = 0; rx_lerr = 1;
    @(negedge clk); rx_lerr = 0;
    rd(A_STAT, d, p); chk("R10 ovr+lerr", d & 32'h1F, 32'h14);
    wr(A_STAT, 32'h04); rd(A_STAT, d, p); chk("R10 ovr cleared only", d & 32'h1F, 32'h10);
    quiet();

    // R5 live flags ignore writes
    @(negedge clk); cts = 1; rts = 0; tx_busy = 1; tx_empty = 0;
    wr(A_STAT, 32'hFFFF_FFE0);
    rd(A_STAT, d, p); chk("R5 live ignore write", d, exp_live(ctrl_m));

    // R6 level select
    @(negedge clk); rx_level = 6'd5; tx_level = 6'd33;
    wr(A_CTRL, 32'h4000); rd(A_STAT, d, p); chk("R6 tx level", {26'd0, d[16:11]}, 33);
    wr(A_CTRL, 32'h0);    rd(A_STAT, d, p); chk("R6 rx level", {26'd0, d[16:11]}, 5);
    cts = 0; tx_busy = 0; tx_empty = 1;
    quiet();

    // R11 interrupt
    @(negedge clk); rx_empty = 0; @(negedge clk); rx_empty = 1;
    wr(A_CTRL, 32'h0004_8000); chk("R11 rx irq", {31'd0, irq}, 1);
    wr(A_CTRL, 32'h0004_0000); chk("R11 disabled", {31'd0, irq}, 0);
    wr(A_CTRL, 32'h0008_8000); chk("R11 wrong ie", {31'd0, irq}, 0);
    @(negedge clk); tx_level = 6'd2; @(negedge clk); tx_level = 6'd8;
    chk("R11 tx irq", {31'd0, irq}, 1);
    wr(A_STAT, 32'h3); chk("R11 cleared", {31'd0, irq}, 0);
    wr(A_CTRL, 0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 2);
      if (op == 0) begin
        logic [31:0] v = $urandom();
        wr(A_CTRL, v); rd(A_CTRL, d, p); chk("R1 rand ctrl", d, v & WMASK);
      end else if (op == 1) begin
        @(negedge clk);
        rx_empty = $urandom_range(0, 1); tx_full = $urandom_range(0, 1);
        tx_empty = $urandom_range(0, 1); cts = $urandom_range(0, 1);
        rts = $urandom_range(0, 1); tx_busy = $urandom_range(0, 1);
        rx_level = 6'($urandom()); tx_level = 6'($urandom());
        rd(A_STAT, d, p); chk("R5 rand live", d & LIVE_MASK, exp_live(ctrl_m));
      end else begin
        logic [7:0] c = 8'($urandom());
        @(negedge clk); rx_empty = $urandom_range(0, 1); rx_data = c;
        rd(A_RXD, d, p);
        chk("R3 rand data", d, {24'd0, c});
        chk("R3 rand pop", {31'd0, p}, {31'd0, !rx_empty});
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule